// File: doc/BRIEF.md
# Accumulator CPU Control Sequencer

An 8-bit accumulator processor core that runs programs from an external memory through a 10-bit address bus, a bidirectional 8-bit data bus and a read/write line. Ten shared sequencer states carry every instruction. The opcode's own bit fields pick the path through those states and select the arithmetic function, the flag and the branch condition. No microcode store is used.

The core has a program counter, an opcode register, an accumulator and three condition flags: carry (C), zero (Z) and negative (N). Arithmetic and logic operations take either a literal byte that follows the opcode or a byte read from an absolute address. The instruction set also has accumulator load and store, an unconditional jump, conditional branches on one flag, and instructions that set or clear a single flag. The arithmetic unit is a separate module. A single shared adder serves add, subtract and compare.

An absolute address is two bytes after the opcode, low byte first. Only bits [1:0] of the second byte are used. They become address bits [9:8].

Top module: `acc_cpu`

## Requirements
- R1: While reset is low and in the first cycle after its release, `addr` is 0 and `rw` is 1. At release the accumulator is 0 and C, Z and N are all 0.
- R2: Every instruction starts with an opcode read at the program counter. It then takes a fixed number of cycles: no-op 2, flag set/clear 3, immediate operation 3, and absolute operation, store, jump or branch 5. A branch costs 5 cycles whether or not it is taken.
- R3: Opcode `1fff0xxx` is an immediate operation on the byte that follows it. The function field fff selects 000 OR, 001 AND, 010 XOR, 011 add-with-carry, 100 load, 101 compare and 110 subtract-with-borrow. The result replaces the accumulator, except for compare.
- R4: Opcode `1fff1xxx` (fff other than 111) takes its operand from an absolute address. The address is the low byte followed by a byte whose bits [1:0] give address bits [9:8]. Its bits [7:2] are ignored. `rw` is 1 during that read.
- R5: Add computes A+B+C and subtract computes A+~B+C. In both cases C becomes the carry out of bit 7, so after a subtract C=1 means no borrow.
- R6: Compare leaves the accumulator unchanged. It sets C when A ≥ B (unsigned), Z when A = B, and N from bit 7 of A−B.
- R7: Every operation of R3/R4 sets Z when its 8-bit result is 0 and copies result bit 7 into N. OR, AND, XOR and load leave C unchanged.
- R8: Opcode `1111xxxx` stores the accumulator at the absolute address given as in R4. It drives `rw` low for exactly one cycle, the last cycle of the instruction, and leaves the flags unchanged.
- R9: Opcode `001xxxxx` followed by an absolute address loads the program counter with that address.
- R10: Opcode `01xxxssv` is a branch. It is followed by a target address. Selector ss picks 00 C, 01 Z, 10 N, and 11 means always taken. Otherwise the branch is taken when the flag equals v. When taken, the program counter loads the target. When not taken, execution continues after the operand bytes.
- R11: Opcode `0001xssv` writes v into the flag picked by ss (00 C, 01 Z, 10 N). ss = 11 changes nothing.
- R12: Opcode `0000xxxx` is a no-op that changes neither the accumulator nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | output | 10 | Memory address |
| data | inout | 8 | Data bus. Memory drives it while `rw` is 1; the core drives the accumulator onto it while `rw` is 0 |
| rw | output | 1 | 1 = read, 0 = write |

## Verification
Cycles are counted from 0, where cycle 0 is the opcode read at address 0 right after reset. A store that begins in cycle k writes in cycle k+4. The bench's program model accumulates each instruction's cycle cost from R2, and adds 3 more for the literal load that runs after a branch that is not taken. The monitor samples on the falling edge of every cycle in which `rw` is low. It compares that cycle number, the address and the stored byte against the next queued expectation. Because of this, a wrong cycle count, a wrong branch direction, or a result or flag that differs from the model all show up at the next store.

// File: rtl/acc_cpu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [2:0]   fn,
  output logic [W-1:0] y,
  output logic         cout
);
  logic         sub, ci;
  logic [W-1:0] bop;
  logic [W:0]   sum;

  assign sub  = (fn == 3'd5) || (fn == 3'd6);
  assign bop  = sub ? ~b : b;
  assign ci   = (fn == 3'd5) ? 1'b1 : ((fn == 3'd3) || (fn == 3'd6)) ? cin : 1'b0;
  assign sum  = {1'b0, a} + {1'b0, bop} + {{W{1'b0}}, ci};
  assign cout = sum[W];

  always_comb begin
    case (fn)
      3'd0:    y = a | b;
      3'd1:    y = a & b;
      3'd2:    y = a ^ b;
      3'd4:    y = b;
      default: y = sum[W-1:0];
    endcase
  end
endmodule

module acc_cpu #(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] addr,
  inout  wire  [DW-1:0] data,
  output logic          rw
);
  localparam int HW = AW - DW;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_FLAG, S_IMM, S_LO, S_HI, S_READ, S_WRITE, S_JUMP, S_BRANCH
  } st_t;

  st_t           st, st_nx;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir, lo, acc;
  logic [HW-1:0] hi;
  logic          fc, fz, fneg;
  logic [DW-1:0] alu_y;
  logic          alu_c;

  wire [AW-1:0] ea      = {hi, lo};
  wire [2:0]    fsel    = ir[6:4];
  wire          is_alu  = ir[7];
  wire          is_sta  = ir[7] && (ir[6:4] == 3'd7);
  wire          is_abs  = ir[3];
  wire          is_jmp  = (ir[7:5] == 3'b001);
  wire          is_br   = (ir[7:6] == 2'b01);
  wire          is_flag = (ir[7:4] == 4'b0001);
  wire [1:0]    sel     = ir[2:1];
  wire          want    = ir[0];
  wire          fnow    = (sel == 2'd0) ? fc : (sel == 2'd1) ? fz : fneg;
  wire          taken   = (sel == 2'd3) || (fnow == want);
  wire          exec    = (st == S_IMM) || (st == S_READ);
  wire          arith   = (fsel == 3'd3) || (fsel == 3'd5) || (fsel == 3'd6);

  acc_alu #(.W(DW)) u_alu (
    .a(acc), .b(data), .cin(fc), .fn(fsel), .y(alu_y), .cout(alu_c)
  );

  assign addr = ((st == S_READ) || (st == S_WRITE)) ? ea : pc;
  assign rw   = (st != S_WRITE);
  assign data = rw ? {DW{1'bz}} : acc;

  always_comb begin
    st_nx = S_FETCH;
    case (st)
      S_FETCH:  st_nx = S_DECODE;
      S_DECODE: begin
        if (is_flag)                            st_nx = S_FLAG;
        else if (is_alu && !is_sta && !is_abs)  st_nx = S_IMM;
        else if (is_alu || is_jmp || is_br)     st_nx = S_LO;
        else                                    st_nx = S_FETCH;
      end
      S_LO:     st_nx = S_HI;
      S_HI: begin
        if (is_sta)      st_nx = S_WRITE;
        else if (is_alu) st_nx = S_READ;
        else if (is_jmp) st_nx = S_JUMP;
        else             st_nx = S_BRANCH;
      end
      default:  st_nx = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_FETCH;
      pc   <= '0;
      ir   <= '0;
      lo   <= '0;
      hi   <= '0;
      acc  <= '0;
      fc   <= 1'b0;
      fz   <= 1'b0;
      fneg <= 1'b0;
    end else begin
      st <= st_nx;
      case (st)
        S_FETCH: begin
          ir <= data;
          pc <= pc + AW'(1);
        end
        S_IMM:    pc <= pc + AW'(1);
        S_LO: begin
          lo <= data;
          pc <= pc + AW'(1);
        end
        S_HI: begin
          hi <= data[HW-1:0];
          pc <= pc + AW'(1);
        end
        S_JUMP:   pc <= ea;
        S_BRANCH: if (taken) pc <= ea;
        S_FLAG: begin
          case (sel)
            2'd0:    fc   <= want;
            2'd1:    fz   <= want;
            2'd2:    fneg <= want;
            default: ;
          endcase
        end
        default: ;
      endcase
      if (exec) begin
        if (fsel != 3'd5) acc <= alu_y;
        fz   <= (alu_y == '0);
        fneg <= alu_y[DW-1];
        if (arith) fc <= alu_c;
      end
    end
  end

  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |=> rw);  // R8
  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |=> (pc == AW'($past(pc) + AW'(1))));  // R2
  AST_IMM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IMM) |=> (pc == AW'($past(pc) + AW'(1))));  // R3
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_JUMP) |=> (pc == $past(ea)));  // R9
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (fsel == 3'd5)) |=> $stable(acc));  // R6
endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  wire  [9:0] addr;
  wire  [7:0] data;
  wire        rw;
  logic [7:0] img [0:1023];
  logic [7:0] mem [0:1023];
  logic [7:0] mm  [0:1023];

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int pa = 0;
  int ca = 0;
  int end_cyc = 0;
  logic [7:0] ma = 8'h00;
  logic mc = 1'b0, mz = 1'b0, mn = 1'b0;

  int    q_cyc[$];
  int    q_adr[$];
  int    q_dat[$];
  string q_req[$];

  always #(CLK_NS/2) clk = ~clk;

  assign data = rw ? mem[addr] : 8'hzz;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= img[i];
    end else if (!rw) begin
      mem[addr] <= data;
    end
  end

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  acc_cpu u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .rw(rw));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int ec, eadr, edat;
    string rq;
    if (rst_n && rw === 1'b0) begin
      if (q_cyc.size() == 0) begin
        chk(1'b0, "R8", "unexpected write at address", int'(addr), -1);
      end else begin
        ec = q_cyc.pop_front();
        eadr = q_adr.pop_front();
        edat = q_dat.pop_front();
        rq = q_req.pop_front();
        chk(cyc == ec, "R2", "write cycle", cyc, ec);
        chk(int'(addr) == eadr, rq, "write address", int'(addr), eadr);
        chk(int'(data) == edat, rq, "stored value", int'(data), edat);
      end
    end
  end

  task automatic eb(input logic [7:0] v);
    img[pa] = v;
    pa++;
  endtask

  task automatic ea2(input int a);
    eb(a[7:0]);
    eb(8'hB4 | {6'd0, a[9:8]});
  endtask

  task automatic m_alu(input int fn, input logic [7:0] b);
    int s;
    logic [7:0] r;
    s = 0;
    r = ma;
    case (fn)
      0: r = ma | b;
      1: r = ma & b;
      2: r = ma ^ b;
      3: begin s = int'(ma) + int'(b) + int'(mc); r = s[7:0]; mc = (s > 255); end
      4: r = b;
      5: begin s = int'(ma) + int'(~b) + 1; r = s[7:0]; mc = (s > 255); end
      6: begin s = int'(ma) + int'(~b) + int'(mc); r = s[7:0]; mc = (s > 255); end
      default: ;
    endcase
    mz = (r == 8'h00);
    mn = r[7];
    if (fn != 5) ma = r;
  endtask

  task automatic op_nop();
    eb(8'h00);
    ca += 2;
  endtask

  task automatic op_flag(input int sel, input bit v);
    eb(8'h10 | {5'd0, sel[1:0], v});
    ca += 3;
    if (sel == 0) mc = v;
    else if (sel == 1) mz = v;
    else if (sel == 2) mn = v;
  endtask

  task automatic op_imm(input int fn, input logic [7:0] b);
    eb({1'b1, fn[2:0], 4'b0000});
    eb(b);
    ca += 3;
    m_alu(fn, b);
  endtask

  task automatic op_abs(input int fn, input int a);
    eb({1'b1, fn[2:0], 4'b1000});
    ea2(a);
    ca += 5;
    m_alu(fn, mm[a]);
  endtask

  task automatic op_sta(input int a, input string rq);
    eb(8'hF8);
    ea2(a);
    q_cyc.push_back(ca + 4);
    q_adr.push_back(a);
    q_dat.push_back(int'(ma));
    q_req.push_back(rq);
    mm[a] = ma;
    ca += 5;
  endtask

  task automatic op_jmp_over();
    eb(8'h20);
    ea2(pa + 6);
    eb(8'hF8); eb(8'hFF); eb(8'h03); eb(8'h00);
    ca += 5;
  endtask

  task automatic op_br(input int sel, input bit v);
    bit t;
    logic fl;
    fl = (sel == 0) ? mc : (sel == 1) ? mz : mn;
    t = (sel == 3) || (fl == v);
    eb(8'h40 | {5'd0, sel[1:0], v});
    ea2(pa + 4);
    eb(8'hC0); eb(8'hEE);
    ca += 5;
    if (!t) begin
      m_alu(4, 8'hEE);
      ca += 3;
    end
  endtask

  initial begin
    int t;
    for (int i = 0; i < 1024; i++) begin img[i] = 8'h00; mm[i] = 8'h00; end
    img[10'h3C0] = 8'h25; mm[10'h3C0] = 8'h25;
    img[10'h1E7] = 8'h3C; mm[10'h1E7] = 8'h3C;

    op_sta(10'h300, "R1");
    op_br(0, 1'b1);  op_sta(10'h301, "R10");
    op_imm(4, 8'h5A); op_sta(10'h302, "R3");
    op_br(0, 1'b0);  op_sta(10'h303, "R10");
    op_imm(0, 8'h81); op_sta(10'h304, "R3");
    op_imm(1, 8'h0F); op_sta(10'h305, "R3");
    op_imm(2, 8'hFF); op_sta(10'h306, "R3");
    op_flag(0, 1'b1); op_imm(3, 8'h10); op_sta(10'h307, "R5");
    op_flag(0, 1'b0); op_imm(3, 8'h0B); op_sta(10'h308, "R5");
    op_flag(0, 1'b1); op_imm(6, 8'h20); op_sta(10'h309, "R5");
    op_br(0, 1'b0);  op_sta(10'h30A, "R5");
    op_imm(5, 8'hF0); op_br(1, 1'b1); op_sta(10'h30B, "R6");
    op_imm(5, 8'hF1); op_br(2, 1'b0); op_sta(10'h30C, "R6");
    op_flag(0, 1'b1); op_imm(4, 8'h00); op_br(0, 1'b1); op_sta(10'h30D, "R7");
    op_br(1, 1'b1);  op_sta(10'h30E, "R7");
    op_imm(4, 8'h7F); op_flag(2, 1'b1); op_br(2, 1'b1); op_sta(10'h30F, "R11");
    op_flag(2, 1'b0); op_br(2, 1'b1); op_sta(10'h310, "R11");
    op_flag(3, 1'b1); op_br(2, 1'b1); op_sta(10'h311, "R8");
    op_abs(4, 10'h302); op_sta(10'h312, "R4");
    op_abs(0, 10'h304); op_flag(0, 1'b0); op_abs(3, 10'h3C0); op_sta(10'h313, "R4");
    op_abs(5, 10'h301); op_br(0, 1'b0); op_sta(10'h314, "R4");
    op_abs(2, 10'h1E7); op_sta(10'h2AA, "R4");
    op_nop(); op_nop(); op_nop(); op_sta(10'h315, "R12");
    op_jmp_over();   op_sta(10'h316, "R9");
    op_br(3, 1'b0);  op_sta(10'h317, "R10");
    t = pa;
    eb(8'h20); ea2(t);
    end_cyc = ca;

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(addr == 10'd0, "R1", "address in reset", int'(addr), 0);
    chk(rw == 1'b1, "R1", "rw in reset", int'(rw), 1);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(addr == 10'd0, "R1", "first opcode address", int'(addr), 0);
    chk(rw == 1'b1, "R1", "rw at first fetch", int'(rw), 1);
    while (cyc < end_cyc + 8) @(posedge clk);
    @(negedge clk);
    chk(q_cyc.size() == 0, "R2", "writes still pending", q_cyc.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL R2: watchdog expired at cycle %0d expected end by %0d", cyc, end_cyc + 8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule